// File: doc/BRIEF.md
# Block-Mode DMA Count and Address Engine

This block is the counting and sequencing core of one DMA channel that moves data in fixed-size blocks. A single load strobe captures a 16-bit control word, a block size, a block count and the two starting addresses. After that, the channel's bus side pulses a one-cycle unit strobe for every byte or word it moves. The engine counts units within the current block. When a block finishes, it refills the unit counter from the held block size and counts the finished block, so equal blocks follow one another with no software action in between.

Each unit can step the source address, the destination address, or both, by one or two, upward or downward. One side is marked as the repeating block area, and at every block end that side's address returns to its loaded value. After the last unit of the final block the engine raises a sticky done flag and a one-cycle end-of-transfer pulse. It then ignores further strobes until the next load.

Top module: `blk_xfer_engine`

## Requirements
- R1: After reset, ctrl_o, unit_cnt_o, blk_cnt_o, src_addr_o and dst_addr_o are all zero, and busy_o, done_o, blk_end_o and xfer_end_o are low.
- R2: One cycle after load_i, ctrl_o equals ctrl_i and unit_cnt_o equals blk_size_i. blk_cnt_o, src_addr_o and dst_addr_o equal their inputs. busy_o is high and done_o is low.
- R3: An accepted strobe with unit_cnt_o other than 1 lowers unit_cnt_o by one. An accepted strobe with unit_cnt_o equal to 1 is the last unit of the block: unit_cnt_o reloads to the loaded block size and blk_end_o is high for the following cycle only.
- R4: Each block end lowers blk_cnt_o by one, wrapping from 0 to 65535. A loaded block size of 0 gives 256 units per block, and a loaded block count of 0 gives 65536 blocks.
- R5: A block end while blk_cnt_o is 1 sets blk_cnt_o to 0, sets done_o, clears busy_o, and raises xfer_end_o for one cycle together with blk_end_o.
- R6: Control bit 2 (source) and bit 4 (destination) enable address stepping on each accepted strobe. Bit 3 (source) and bit 5 (destination) select a decrement instead of an increment. The step is 2 when bit 0 (word size) is set and 1 otherwise, with wrap at the address width.
- R7: Control bit 6 picks the repeating side: 1 means destination, 0 means source. At each block end that side's address becomes the value loaded for it. The other side keeps stepping.
- R8: A strobe has no effect on counters, addresses or pulses while busy_o is low, while control bit 1 (block enable) is clear, or after done_o has been set. done_o stays high until the next load_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Load all settings and arm the channel |
| ctrl_i | input | 16 | Control word written on load |
| blk_size_i | input | 8 | Units per block (0 = 256) |
| blk_cnt_i | input | 16 | Blocks to transfer (0 = 65536) |
| src_addr_i | input | 24 | Starting source address |
| dst_addr_i | input | 24 | Starting destination address |
| unit_i | input | 1 | One pulse per byte or word moved |
| ctrl_o | output | 16 | Held control word |
| unit_cnt_o | output | 8 | Units left in the current block |
| blk_cnt_o | output | 16 | Blocks left |
| src_addr_o | output | 24 | Current source address |
| dst_addr_o | output | 24 | Current destination address |
| busy_o | output | 1 | Channel armed and not finished |
| done_o | output | 1 | Final block completed (sticky) |
| blk_end_o | output | 1 | Pulse after the last unit of any block |
| xfer_end_o | output | 1 | Pulse after the last unit of the final block |

## Verification
The assertions assume that load_i and unit_i are synchronous single-cycle controls, and that a load is never accepted in the same cycle as a strobe that would count. The stimulus drives each strobe or load in its own cycle with an idle cycle after it, so the two never overlap. Random control words, block sizes from 1 to 4 and block counts from 1 to 3 keep transfers short. Sizes and counts of zero are exercised only in directed runs that stop long before the wrap would matter.

// File: rtl/blk_xfer_pkg.sv
package blk_xfer_pkg;
  typedef struct packed {
    logic blk_dst;
    logic dst_dec;
    logic dst_step;
    logic src_dec;
    logic src_step;
    logic blk_en;
    logic word;
  } ctrl_t;

  function automatic ctrl_t decode_ctrl(input logic [15:0] r);
    ctrl_t c;
    c.word     = r[0];
    c.blk_en   = r[1];
    c.src_step = r[2];
    c.src_dec  = r[3];
    c.dst_step = r[4];
    c.dst_dec  = r[5];
    c.blk_dst  = r[6];
    return c;
  endfunction
endpackage

// File: rtl/blk_xfer_counters.sv
module blk_xfer_counters #(
  parameter int UW = 8,
  parameter int BW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [UW-1:0] size_i,
  input  logic [BW-1:0] cnt_i,
  input  logic          step_i,
  output logic [UW-1:0] unit_o,
  output logic [BW-1:0] blk_o,
  output logic          blk_last_o,
  output logic          xfer_last_o
);
  localparam logic [UW-1:0] UNIT_ONE = UW'(1);
  localparam logic [BW-1:0] BLK_ONE  = BW'(1);

  logic [UW-1:0] size_q, unit_q;
  logic [BW-1:0] blk_q;

  assign blk_last_o  = step_i && (unit_q == UNIT_ONE);
  assign xfer_last_o = blk_last_o && (blk_q == BLK_ONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      size_q <= '0;
      unit_q <= '0;
      blk_q  <= '0;
    end else if (load_i) begin
      size_q <= size_i;
      unit_q <= size_i;
      blk_q  <= cnt_i;
    end else if (step_i) begin
      if (blk_last_o) begin
        unit_q <= size_q;   // zero size wraps to a full 2**UW block
        blk_q  <= blk_q - BLK_ONE;
      end else begin
        unit_q <= unit_q - UNIT_ONE;
      end
    end
  end

  assign unit_o = unit_q;
  assign blk_o  = blk_q;

  a_r3_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (blk_last_o && !load_i) |=> (unit_q == size_q));
  a_r3_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step_i && !load_i) |=> ($stable(unit_q) && $stable(blk_q)));
  a_r4_blk_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (blk_last_o && !load_i) |=> (blk_q == $past(blk_q) - BLK_ONE));
endmodule

// File: rtl/blk_xfer_addr.sv
module blk_xfer_addr #(
  parameter int AW = 24
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] addr_i,
  input  logic          adv_i,
  input  logic          step_en_i,
  input  logic          dec_i,
  input  logic          word_i,
  input  logic          restore_i,
  output logic [AW-1:0] addr_o
);
  logic [AW-1:0] base_q, addr_q, delta;

  assign delta = word_i ? AW'(2) : AW'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      addr_q <= '0;
    end else if (load_i) begin
      base_q <= addr_i;
      addr_q <= addr_i;
    end else if (restore_i) begin
      addr_q <= base_q;
    end else if (adv_i && step_en_i) begin
      addr_q <= dec_i ? addr_q - delta : addr_q + delta;
    end
  end

  assign addr_o = addr_q;

  a_r6_still: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !restore_i && !(adv_i && step_en_i)) |=> $stable(addr_q));
  a_r7_restore: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (restore_i && !load_i) |=> (addr_q == base_q));
endmodule

// File: rtl/blk_xfer_engine.sv
module blk_xfer_engine #(
  parameter int AW = 24,
  parameter int UW = 8,
  parameter int BW = 16,
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] ctrl_i,
  input  logic [UW-1:0] blk_size_i,
  input  logic [BW-1:0] blk_cnt_i,
  input  logic [AW-1:0] src_addr_i,
  input  logic [AW-1:0] dst_addr_i,
  input  logic          unit_i,
  output logic [CW-1:0] ctrl_o,
  output logic [UW-1:0] unit_cnt_o,
  output logic [BW-1:0] blk_cnt_o,
  output logic [AW-1:0] src_addr_o,
  output logic [AW-1:0] dst_addr_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          blk_end_o,
  output logic          xfer_end_o
);
  import blk_xfer_pkg::*;

  localparam int NSIDE = 2;  // 0: source, 1: destination

  logic [CW-1:0] ctrl_q;
  ctrl_t         cfg;
  logic          busy_q, done_q, bend_q, xend_q;
  logic          accept, blk_last, xfer_last;

  logic [AW-1:0] side_in   [NSIDE];
  logic [AW-1:0] side_out  [NSIDE];
  logic          side_step [NSIDE];
  logic          side_dec  [NSIDE];
  logic          side_rst  [NSIDE];

  assign cfg    = decode_ctrl(16'(ctrl_q));
  assign accept = unit_i && busy_q && cfg.blk_en && !load_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      bend_q <= 1'b0;
      xend_q <= 1'b0;
    end else begin
      bend_q <= blk_last;
      xend_q <= xfer_last;
      if (load_i) begin
        ctrl_q <= ctrl_i;
        busy_q <= 1'b1;
        done_q <= 1'b0;
      end else if (xfer_last) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end
    end
  end

  blk_xfer_counters #(.UW(UW), .BW(BW)) cnt_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (load_i),
    .size_i      (blk_size_i),
    .cnt_i       (blk_cnt_i),
    .step_i      (accept),
    .unit_o      (unit_cnt_o),
    .blk_o       (blk_cnt_o),
    .blk_last_o  (blk_last),
    .xfer_last_o (xfer_last)
  );

  assign side_in[0]   = src_addr_i;
  assign side_in[1]   = dst_addr_i;
  assign side_step[0] = cfg.src_step;
  assign side_step[1] = cfg.dst_step;
  assign side_dec[0]  = cfg.src_dec;
  assign side_dec[1]  = cfg.dst_dec;
  assign side_rst[0]  = blk_last && !cfg.blk_dst;
  assign side_rst[1]  = blk_last && cfg.blk_dst;

  for (genvar g = 0; g < NSIDE; g++) begin : g_side
    blk_xfer_addr #(.AW(AW)) addr_i (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .load_i    (load_i),
      .addr_i    (side_in[g]),
      .adv_i     (accept),
      .step_en_i (side_step[g]),
      .dec_i     (side_dec[g]),
      .word_i    (cfg.word),
      .restore_i (side_rst[g]),
      .addr_o    (side_out[g])
    );
  end

  assign src_addr_o = side_out[0];
  assign dst_addr_o = side_out[1];
  assign ctrl_o     = ctrl_q;
  assign busy_o     = busy_q;
  assign done_o     = done_q;
  assign blk_end_o  = bend_q;
  assign xfer_end_o = xend_q;

  a_r5_end_pair: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_end_o |-> (blk_end_o && done_o && !busy_o && blk_cnt_o == '0));
  a_r8_done_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !load_i) |=> done_o);
  a_r8_ignore: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !load_i) |=> ($stable(unit_cnt_o) && $stable(blk_cnt_o)
                              && $stable(src_addr_o) && $stable(dst_addr_o)
                              && !blk_end_o));
  a_r5_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && done_o));
endmodule

// File: tb/blk_xfer_engine_tb.sv
module blk_xfer_engine_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load = 1'b0;
  logic [15:0] ctrl = '0;
  logic [7:0]  bsize = '0;
  logic [15:0] bcnt = '0;
  logic [23:0] saddr = '0, daddr = '0;
  logic        unit = 1'b0;
  logic [15:0] ctrl_o;
  logic [7:0]  unit_cnt;
  logic [15:0] blk_cnt;
  logic [23:0] src_o, dst_o;
  logic        busy, done, bend, xend;

  int errors = 0, checks = 0;

  // bench model
  logic [15:0] m_ctrl = '0;
  logic [7:0]  m_size = '0, m_unit = '0;
  logic [15:0] m_blk = '0;
  logic [23:0] m_sbase = '0, m_dbase = '0, m_src = '0, m_dst = '0;
  logic        m_busy = 1'b0, m_done = 1'b0, m_bend = 1'b0, m_xend = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  blk_xfer_engine dut_i (
    .clk_i(clk), .rst_ni(rst_n), .load_i(load), .ctrl_i(ctrl),
    .blk_size_i(bsize), .blk_cnt_i(bcnt), .src_addr_i(saddr), .dst_addr_i(daddr),
    .unit_i(unit), .ctrl_o(ctrl_o), .unit_cnt_o(unit_cnt), .blk_cnt_o(blk_cnt),
    .src_addr_o(src_o), .dst_addr_o(dst_o), .busy_o(busy), .done_o(done),
    .blk_end_o(bend), .xfer_end_o(xend)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic chk_all(input string req);
    chk(req, "ctrl",     32'(ctrl_o),   32'(m_ctrl));
    chk(req, "unit_cnt", 32'(unit_cnt), 32'(m_unit));
    chk(req, "blk_cnt",  32'(blk_cnt),  32'(m_blk));
    chk(req, "src",      32'(src_o),    32'(m_src));
    chk(req, "dst",      32'(dst_o),    32'(m_dst));
    chk(req, "busy",     32'(busy),     32'(m_busy));
    chk(req, "done",     32'(done),     32'(m_done));
    chk(req, "blk_end",  32'(bend),     32'(m_bend));
    chk(req, "xfer_end", 32'(xend),     32'(m_xend));
  endtask

  task automatic do_load(input logic [15:0] c, input logic [7:0] s, input logic [15:0] n,
                         input logic [23:0] sa, input logic [23:0] da);
    @(negedge clk);
    load = 1'b1; ctrl = c; bsize = s; bcnt = n; saddr = sa; daddr = da;
    @(negedge clk);
    load = 1'b0;
    m_ctrl = c; m_size = s; m_unit = s; m_blk = n;
    m_sbase = sa; m_dbase = da; m_src = sa; m_dst = da;
    m_busy = 1'b1; m_done = 1'b0; m_bend = 1'b0; m_xend = 1'b0;
    chk_all("R2");
  endtask

  task automatic strobe(input string req);
    logic [23:0] st;
    @(negedge clk);
    unit = 1'b1;
    @(negedge clk);
    unit = 1'b0;
    m_bend = 1'b0; m_xend = 1'b0;
    if (m_busy && m_ctrl[1]) begin
      st = m_ctrl[0] ? 24'd2 : 24'd1;
      if (m_ctrl[2]) m_src = m_ctrl[3] ? m_src - st : m_src + st;
      if (m_ctrl[4]) m_dst = m_ctrl[5] ? m_dst - st : m_dst + st;
      if (m_unit == 8'd1) begin
        m_unit = m_size;
        m_bend = 1'b1;
        if (m_ctrl[6]) m_dst = m_dbase; else m_src = m_sbase;
        if (m_blk == 16'd1) begin
          m_blk = '0; m_done = 1'b1; m_busy = 1'b0; m_xend = 1'b1;
        end else begin
          m_blk = m_blk - 16'd1;
        end
      end else begin
        m_unit = m_unit - 8'd1;
      end
    end
    chk_all(req);
    // pulses must be gone one cycle later
    @(negedge clk);
    chk(req, "blk_end drop", 32'(bend), 32'd0);
    chk(req, "xfer_end drop", 32'(xend), 32'd0);
    m_bend = 1'b0; m_xend = 1'b0;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int seed;
    seed = 32'h5eed_1234;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    chk_all("R1");
    rst_n = 1'b1;
    @(negedge clk);
    chk_all("R1");
    // R8: strobe while idle is ignored
    strobe("R8 idle");

    // R3 R5 R7: directed, 3 units x 2 blocks, source repeating, both stepping up by word
    do_load(16'h0017, 8'd3, 16'd2, 24'h00_1000, 24'h00_2000);
    repeat (6) strobe("R3 R5 R7 directed");
    // R8: strobe after done ignored
    strobe("R8 after done");
    chk("R8", "done held", 32'(done), 32'd1);

    // R8: block enable clear
    do_load(16'h0015, 8'd2, 16'd1, 24'h10, 24'h20);
    repeat (3) strobe("R8 blk_en clear");

    // R6: decrement wrap from zero, destination repeating
    do_load(16'h007E, 8'd2, 16'd2, 24'h0, 24'h0);
    repeat (4) strobe("R6 R7 decrement wrap");

    // R4: size 0 means 256 units
    do_load(16'h0006, 8'd0, 16'd2, 24'h100, 24'h0);
    repeat (256) strobe("R4 size zero");
    chk("R4", "one block done", 32'(blk_cnt), 32'd1);

    // R4: count 0 means 65536 blocks
    do_load(16'h0002, 8'd1, 16'd0, 24'h0, 24'h0);
    repeat (3) strobe("R4 count zero");
    chk("R4", "not done", 32'(done), 32'd0);

    // random runs
    for (int t = 0; t < 40; t++) begin
      logic [15:0] c;
      logic [7:0]  s;
      logic [15:0] n;
      int k;
      c = 16'($urandom) | 16'h0002;
      if (t % 7 == 0) c[1] = 1'b0;
      s = 8'($urandom_range(4, 1));
      n = 16'($urandom_range(3, 1));
      do_load(c, s, n, 24'($urandom), 24'($urandom));
      k = int'(s) * int'(n) + $urandom_range(2, 0);
      for (int i = 0; i < k; i++) strobe("R3 R6 R7 random");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule